// File: doc/BRIEF.md
# Signed Magnitude Threshold Detector

This block takes a small two's-complement sample and an unsigned threshold one bit narrower, and raises a single flag when the sample's magnitude is strictly larger than the threshold. The magnitude is formed in two steps. A row of XOR gates, driven by the sign bit, inverts the data bits. A ripple chain made only of half-adder cells then adds the sign bit into the inverted value. A comparator cascade, working from the most significant bit down, decides greater-than. Each bit position hands an equality flag and a greater flag down to the next position.

The most negative code has no positive counterpart that fits in the magnitude width. Its magnitude bits come out as all zeros. The comparator is not widened for this case. Instead, a detect signal flips the final comparison result, so that this code reads as the largest magnitude of all. The flag is captured in a register with a synchronous active-high reset, for timing closure.

Top module: `mag_thresh_detect`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `above` is 0 after that edge, whatever the data and threshold inputs are.
- R2: `above` is registered. It shows the result for the inputs present at the previous rising edge, and it does not change between edges.
- R3: When `data_in[3]` is 0, the magnitude is `data_in[2:0]` unchanged.
- R4: When `data_in[3]` is 1 and the low bits are not all zero, the magnitude is the two's-complement negation. For example, 4'b1001 gives magnitude 7.
- R5: `above` is 1 only if the magnitude is strictly greater than `threshold`. An equal magnitude gives 0.
- R6: The code 4'b1000 has magnitude 8, so `above` is 1 for every threshold from 0 to 7.
- R7: 4'b1110 has magnitude 2. `above` is 1 for thresholds 0 and 1, and 0 for thresholds 2 and above.
- R8: The comparison is decided at the highest bit position where the magnitude and the threshold differ. Lower bits have no effect once a higher bit differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 4 | Two's-complement sample |
| threshold | input | 3 | Unsigned threshold |
| above | output | 1 | Registered flag: magnitude > threshold |

## Verification
The bench drives all 128 combinations of sample and threshold, and compares each one with an integer absolute value reference. It also runs directed vectors at the edges.

- **Most negative code.** A design that dropped the correction would see magnitude 0 for 4'b1000 and report 0.
- **Equal magnitude.** A design that used greater-or-equal would raise the flag on a tie.
- **Negation off by one.** A negation that left out the increment would give 6 instead of 7 for 4'b1001.
- **Bit priority.** Vectors whose higher and lower bits disagree expose a cascade that lets a lower bit override a higher decision.
- **Reset and latency.** Reset with a flag-raising input, and the one-cycle register delay, are checked directly.

// File: rtl/mag_det_pkg.sv
package mag_det_pkg;
  // Cascade state handed from one comparator bit to the next lower one
  typedef struct packed {
    logic gt;
    logic eq;
  } cmp_link_t;
endpackage

// File: rtl/sign_xor_row.sv
module sign_xor_row #(
  parameter int N = 3
) (
  input  logic         sign,
  input  logic [N-1:0] bits_in,
  output logic [N-1:0] bits_out
);
  for (genvar i = 0; i < N; i++) begin : g_x
    assign bits_out[i] = bits_in[i] ^ sign;
  end
endmodule

// File: rtl/half_add_cell.sv
module half_add_cell (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
  import mag_det_pkg::*;
(
  input  cmp_link_t up,
  input  logic      m,
  input  logic      t,
  output cmp_link_t dn
);
  assign dn.gt = up.gt | (up.eq & m & ~t);
  assign dn.eq = up.eq & ~(m ^ t);
endmodule

// File: rtl/mag_thresh_detect.sv
module mag_thresh_detect
  import mag_det_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_in,
  input  logic [W-2:0] threshold,
  output logic         above
);
  localparam int M = W - 1;

  logic         sign;
  logic [M-1:0] inv;
  logic [M-1:0] mag;
  logic [M:0]   carry;
  cmp_link_t    link [M+1];
  logic         min_code;
  logic         flag_c;

  assign sign = data_in[W-1];

  sign_xor_row #(.N(M)) i_inv (
    .sign(sign), .bits_in(data_in[M-1:0]), .bits_out(inv)
  );

  // Increment chain: the sign bit is the injected one
  assign carry[0] = sign;
  for (genvar i = 0; i < M; i++) begin : g_inc
    half_add_cell i_ha (
      .a(inv[i]), .b(carry[i]), .s(mag[i]), .co(carry[i+1])
    );
  end

  // Cascade from MSB down; link[0] enters at bit M-1
  assign link[0] = '{gt: 1'b0, eq: 1'b1};
  for (genvar k = 0; k < M; k++) begin : g_cmp
    cmp_bit_cell i_cb (
      .up(link[k]), .m(mag[M-1-k]), .t(threshold[M-1-k]), .dn(link[k+1])
    );
  end

  assign min_code = sign & ~(|data_in[M-1:0]);
  assign flag_c   = link[M].gt ^ min_code;

  always_ff @(posedge clk) begin
    if (rst) above <= 1'b0;
    else     above <= flag_c;
  end

  // R1: reset clears the flag
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !above);
  // R3: positive samples pass their low bits through as magnitude
  p_pos_pass_r3: assert property (@(posedge clk) disable iff (rst)
    !data_in[W-1] |-> mag == data_in[M-1:0]);
  // R4: for negative samples, magnitude plus low bits wrap to zero
  p_neg_sum_r4: assert property (@(posedge clk) disable iff (rst)
    data_in[W-1] |-> M'(mag + data_in[M-1:0]) == '0);
  // R6: most negative code always raises the flag
  p_min_code_r6: assert property (@(posedge clk) disable iff (rst)
    (data_in == {1'b1, {M{1'b0}}}) |=> above);
  // R5: a tie with a non-minimum code never raises the flag
  p_tie_low_r5: assert property (@(posedge clk) disable iff (rst)
    (mag == threshold && !min_code) |=> !above);
  // R8: greater and equal never hold together at the cascade end
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(link[M].gt && link[M].eq));
endmodule

// File: tb/test_mag_thresh_detect.sv
module test_mag_thresh_detect;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] data_in;
  logic [2:0] threshold;
  logic       above;
  int         n_run = 0;
  int         n_fail = 0;

  // {data, threshold, expected}
  localparam logic [7:0] VEC [12] = '{
    {4'b1001, 3'd7, 1'b0},  // R4 R5: 7 vs 7
    {4'b1001, 3'd6, 1'b1},  // R4
    {4'b1000, 3'd7, 1'b1},  // R6
    {4'b1000, 3'd0, 1'b1},  // R6
    {4'b1110, 3'd1, 1'b1},  // R7
    {4'b1110, 3'd2, 1'b0},  // R7 R5
    {4'b0011, 3'd3, 1'b0},  // R3 R5
    {4'b0100, 3'd3, 1'b1},  // R3 R8
    {4'b0011, 3'd4, 1'b0},  // R8
    {4'b0101, 3'd2, 1'b1},  // R8
    {4'b1111, 3'd0, 1'b1},  // R4
    {4'b0000, 3'd0, 1'b0}   // R3 R5
  };

  mag_thresh_detect #(.W(4)) i_mag_thresh_detect (
    .clk(clk), .rst(rst), .data_in(data_in), .threshold(threshold), .above(above)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic exp, input string req);
    n_run++;
    if (above !== exp) begin
      n_fail++;
      $display("FAIL %s data=%b thr=%0d got=%b exp=%b", req, data_in, threshold, above, exp);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic [2:0] t);
    data_in = d; threshold = t;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; data_in = 4'b1000; threshold = 3'd0;
    @(negedge clk); @(negedge clk);
    check(1'b0, "R1 reset with flag-raising input");
    rst = 1'b0;
    @(negedge clk);
    check(1'b1, "R1 flag after reset release");

    // R2: new input giving 0; before the edge the old value holds
    data_in = 4'b0001; threshold = 3'd5;
    #1 check(1'b1, "R2 held before edge");
    @(negedge clk);
    check(1'b0, "R2 updated after edge");

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i][7:4], VEC[i][3:1]);
      check(VEC[i][0], "R3-R8 table vector");
    end

    // Full sweep against an integer reference
    for (int d = 0; d < 16; d++) begin
      for (int t = 0; t < 8; t++) begin
        int mag_ref;
        mag_ref = (d >= 8) ? 16 - d : d;
        apply(4'(d), 3'(t));
        if (d >= 8) check(mag_ref > t, "R4/R6 sweep negative");
        else        check(mag_ref > t, "R3/R5 sweep positive");
      end
    end

    // R1 again mid-run
    rst = 1'b1;
    apply(4'b1000, 3'd3);
    check(1'b0, "R1 reset mid-run");
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule